// File: doc/BRIEF.md
# Decimal Two-Digit Adder with Seven-Segment Outputs

The block adds two packed decimal operands of two digits each, plus a single carry-in bit, and produces a three-digit decimal result. Each digit position has its own stage. A stage forms the plain binary sum of its two digits and the carry arriving from the position below it. When that sum is larger than nine, the stage corrects it back into the decimal range and raises a decimal carry, which goes on to the next position up. The carry from the top position is the hundreds digit, and that digit can only be 0 or 1.

Every operand digit and every sum digit also drives an active-low seven-segment pattern. The hundreds digit drives a fixed glyph of either 0 or 1. A separate flag reports that at least one operand digit holds a code from 10 to 15. Even then, the sum is still formed by the same binary-add-and-correct rule. The block is purely combinational and has no clock.

Top module: `bcd_sum_display`

## Requirements
- R1: For each digit position, let t be the binary sum of the two digits and the carry into that position, with t in the range 0 to 31. The position's sum digit is t when t is 9 or less. Otherwise it is (t-10) modulo 16.
- R2: The decimal carry out of a position is 1 exactly when t > 9. The carry out of the ones position (digit 0) is the carry into the tens position (digit 1), and `carry_in` is the carry into digit 0.
- R3: `carry_out` is the decimal carry of the top digit position. When all operand digits are 0 to 9, the value 100*carry_out + 10*tens + ones equals A + B + carry_in. A and B are the operands read as decimal numbers.
- R4: `bad_digit` is 1 exactly when at least one of the four operand digits is greater than 9.
- R5: Each segment pattern is active low, so a 0 bit means the segment is lit. Bits 0 to 6 are top, upper right, lower right, bottom, lower left, upper left and middle. Digits 0 to 9 give these patterns, in hex: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10.
- R6: A digit code from 10 to 15 gives the pattern 7F, which means every segment is dark.
- R7: `carry_seg` is 40 (glyph 0) when `carry_out` is 0 and 79 (glyph 1) when it is 1. Its middle segment is never lit.
- R8: `a_seg` and `b_seg` show each operand digit with the R5/R6 patterns. Digit i uses bits 7i+6 down to 7i.
- R9: When `bad_digit` is 1, the sum digits, `carry_out` and the sum patterns still follow R1, R2, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_digits | input | 8 | Operand A, ones digit in bits 3:0 and tens digit in bits 7:4 |
| b_digits | input | 8 | Operand B, same layout as A |
| carry_in | input | 1 | Carry into the ones digit |
| sum_digits | output | 8 | Sum, ones digit in bits 3:0 and tens digit in bits 7:4 |
| carry_out | output | 1 | Hundreds digit, 0 or 1 |
| bad_digit | output | 1 | Set when any operand digit is above 9 |
| sum_seg | output | 14 | Active-low patterns of the sum digits, 7 bits per digit |
| carry_seg | output | 7 | Active-low glyph of the hundreds digit |
| a_seg | output | 14 | Active-low patterns of the operand A digits |
| b_seg | output | 14 | Active-low patterns of the operand B digits |

## Verification
The bench builds the block with its default parameter, DIGITS = 2. At that size every code of all four operand digits and both carry-in values can be applied, which is 131072 vectors. The sweep therefore covers every valid decimal pair, including the worst case 99 + 99 + 1. It also covers every out-of-range code, so both the invalid-digit flag and the dark pattern for codes 10 to 15 are checked against arithmetic computed in the bench.

// File: rtl/bcd_sum_pkg.sv
package bcd_sum_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  localparam seg_t SEG_DARK = 7'h7F;

  // true for codes 10..15
  function automatic logic above_nine(input digit_t d);
    return d[3] & (d[2] | d[1]);
  endfunction
endpackage

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_sum_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   seg_no
);
  always_comb begin
    case (digit_i)
      4'd0:    seg_no = 7'h40;
      4'd1:    seg_no = 7'h79;
      4'd2:    seg_no = 7'h24;
      4'd3:    seg_no = 7'h30;
      4'd4:    seg_no = 7'h19;
      4'd5:    seg_no = 7'h12;
      4'd6:    seg_no = 7'h02;
      4'd7:    seg_no = 7'h78;
      4'd8:    seg_no = 7'h00;
      4'd9:    seg_no = 7'h10;
      default: seg_no = SEG_DARK;
    endcase
  end

  always_comb begin
    if (!above_nine(digit_i)) begin
      AST_SEG_LIT_DIGIT: assert ($countones(~seg_no) >= 2); // R5
    end
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_sum_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   c_i,
  output digit_t s_o,
  output logic   c_o
);
  logic [DIGIT_W:0] raw;
  logic             over;

  assign raw  = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, c_i};
  // binary carry-out, or a 4-bit result in 10..15
  assign over = raw[DIGIT_W] | (raw[3] & (raw[2] | raw[1]));
  assign s_o  = raw[DIGIT_W-1:0] + (over ? 4'd6 : 4'd0);
  assign c_o  = over;

  always_comb begin
    if (!above_nine(a_i) && !above_nine(b_i)) begin
      AST_DIGIT_BALANCE: assert ((10 * int'(c_o) + int'(s_o)) ==
                                 (int'(a_i) + int'(b_i) + int'(c_i))); // R1
      AST_DIGIT_RANGE: assert (!above_nine(s_o)); // R2
    end
  end
endmodule

// File: rtl/carry_glyph.sv
module carry_glyph
  import bcd_sum_pkg::*;
(
  input  logic carry_i,
  output seg_t seg_no
);
  // glyph 0 or 1: right-hand pair always lit, middle always dark
  assign seg_no = {1'b1, carry_i, carry_i, carry_i, 1'b0, 1'b0, carry_i};

  always_comb begin
    AST_GLYPH_SHAPE: assert ($countones(~seg_no) == (carry_i ? 2 : 6)); // R7
  end
endmodule

// File: rtl/bcd_sum_display.sv
module bcd_sum_display
  import bcd_sum_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [DIGITS*DIGIT_W-1:0] a_digits,
  input  logic [DIGITS*DIGIT_W-1:0] b_digits,
  input  logic                      carry_in,
  output logic [DIGITS*DIGIT_W-1:0] sum_digits,
  output logic                      carry_out,
  output logic                      bad_digit,
  output logic [DIGITS*SEG_W-1:0]   sum_seg,
  output logic [SEG_W-1:0]          carry_seg,
  output logic [DIGITS*SEG_W-1:0]   a_seg,
  output logic [DIGITS*SEG_W-1:0]   b_seg
);
  localparam int OPER_DIGITS = 2 * DIGITS;

  logic [DIGITS:0]      chain;
  logic [OPER_DIGITS-1:0] digit_bad;

  assign chain[0] = carry_in;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_pos
    digit_t a_d, b_d, s_d;

    assign a_d = a_digits[gi*DIGIT_W +: DIGIT_W];
    assign b_d = b_digits[gi*DIGIT_W +: DIGIT_W];
    assign sum_digits[gi*DIGIT_W +: DIGIT_W] = s_d;

    assign digit_bad[2*gi]   = above_nine(a_d);
    assign digit_bad[2*gi+1] = above_nine(b_d);

    bcd_digit_adder i_add (
      .a_i (a_d),
      .b_i (b_d),
      .c_i (chain[gi]),
      .s_o (s_d),
      .c_o (chain[gi+1])
    );

    bcd_seg_decoder i_sum_seg (.digit_i(s_d), .seg_no(sum_seg[gi*SEG_W +: SEG_W]));
    bcd_seg_decoder i_a_seg   (.digit_i(a_d), .seg_no(a_seg[gi*SEG_W +: SEG_W]));
    bcd_seg_decoder i_b_seg   (.digit_i(b_d), .seg_no(b_seg[gi*SEG_W +: SEG_W]));

    always_comb begin
      if (!bad_digit) begin
        AST_SUM_IN_RANGE: assert (!above_nine(s_d)); // R4
      end
    end
  end

  assign bad_digit = |digit_bad;
  assign carry_out = chain[DIGITS];

  carry_glyph i_glyph (.carry_i(carry_out), .seg_no(carry_seg));
endmodule

// File: tb/test_bcd_sum_display.sv
module test_bcd_sum_display;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a_digits, b_digits, sum_digits;
  logic        carry_in, carry_out, bad_digit;
  logic [13:0] sum_seg, a_seg, b_seg;
  logic [6:0]  carry_seg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bcd_sum_display i_bcd_sum_display (
    .a_digits(a_digits), .b_digits(b_digits), .carry_in(carry_in),
    .sum_digits(sum_digits), .carry_out(carry_out), .bad_digit(bad_digit),
    .sum_seg(sum_seg), .carry_seg(carry_seg), .a_seg(a_seg), .b_seg(b_seg)
  );

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 40) $display("FAIL %s actual=%0h expected=%0h a=%h b=%h cin=%0d",
                               req, act, exp, a_digits, b_digits, carry_in);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a_digits = '0; b_digits = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state with zero operands
    check("R3 idle carry", int'(carry_out), 0);
    check("R1 idle sum", int'(sum_digits), 0);
    check("R7 idle glyph", int'(carry_seg), 'h40);

    for (int v = 0; v < 131072; v++) begin
      int a0, a1, b0, b1, ci, t0, t1, s0, s1, c1, c2;
      logic [16:0] vv;
      @(posedge clk);
      vv = v[16:0];
      a0 = int'(vv[3:0]);   a1 = int'(vv[7:4]);
      b0 = int'(vv[11:8]);  b1 = int'(vv[15:12]);
      ci = int'(vv[16]);
      a_digits = {vv[7:4], vv[3:0]};
      b_digits = {vv[15:12], vv[11:8]};
      carry_in = vv[16];
      @(negedge clk);

      t0 = a0 + b0 + ci;
      c1 = (t0 > 9) ? 1 : 0;
      s0 = (t0 > 9) ? ((t0 - 10) & 15) : t0;
      t1 = a1 + b1 + c1;
      c2 = (t1 > 9) ? 1 : 0;
      s1 = (t1 > 9) ? ((t1 - 10) & 15) : t1;

      check("R1 ones digit", int'(sum_digits[3:0]), s0);
      check("R2 tens digit via chained carry", int'(sum_digits[7:4]), s1);
      check("R2 carry_out", int'(carry_out), c2);
      check("R4 bad_digit", int'(bad_digit),
            (a0 > 9 || a1 > 9 || b0 > 9 || b1 > 9) ? 1 : 0);
      check((s0 > 9) ? "R6 ones dark" : "R5 ones pattern",
            int'(sum_seg[6:0]), int'(ref_seg(s0)));
      check((s1 > 9) ? "R6 tens dark" : "R5 tens pattern",
            int'(sum_seg[13:7]), int'(ref_seg(s1)));
      check("R7 hundreds glyph", int'(carry_seg), c2 ? 'h79 : 'h40);
      check("R8 echo A", int'(a_seg), int'({ref_seg(a1), ref_seg(a0)}));
      check("R8 echo B", int'(b_seg), int'({ref_seg(b1), ref_seg(b0)}));
      if (a0 <= 9 && a1 <= 9 && b0 <= 9 && b1 <= 9)
        check("R3 decimal total", 100 * int'(carry_out) + 10 * int'(sum_digits[7:4])
              + int'(sum_digits[3:0]), (10 * a1 + a0) + (10 * b1 + b0) + ci);
      else
        check("R9 invalid still summed", int'({carry_out, sum_digits}),
              (c2 << 8) | (s1 << 4) | s0);
    end
    finish_run();
  end
endmodule